// File: doc/BRIEF.md
# Instruction TLB Replacement-Order Tracker

This block holds the replacement order for a small, fully associative instruction TLB. The order is kept as a pairwise "who was used more recently" field packed into the most significant bits of a 32-bit control word. Every other bit of that word is stored and returned unchanged. The TLB arrays and the address match logic sit outside this block.

Each time the TLB hits on an entry, or refills one, the caller pulses a touch strobe with that entry's index. The block then rewrites the order field with a fixed clear mask followed by a fixed set mask. Each cycle it also decodes the stored field into the index of the entry to replace on the next refill. When the field holds a pattern that names no entry, it raises a flag instead.

Software can overwrite the whole control word through a write port. This can leave the field in an inconsistent state, and that is the case the flag reports.

Top module: `tlb_lru_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `csr_q` is 0x00000000, `victim_idx` is 3 and `state_bad` is 0.
- R2: A cycle with `csr_wr_en` high loads `csr_wr_data` into `csr_q` at the next clock edge. `victim_idx` and `state_bad` follow the stored word without a further register.
- R3: The order field is `csr_q[31:26]`. The first match in the order 0, 1, 2, 3 sets `victim_idx` as follows:
  - entry 0 when bits 31, 30 and 29 are all 1;
  - entry 1 when bit 31 is 0 and bits 28 and 27 are 1;
  - entry 2 when bits 30 and 28 are 0 and bit 26 is 1;
  - entry 3 when bits 29, 27 and 26 are all 0.
- R4: When no pattern of R3 matches (for example a field of 010001, word 0x44000000), `state_bad` is 1 and `victim_idx` is 0.
- R5: A touch of entry 0 clears bits 31, 30 and 29 and keeps bits 28 to 26.
- R6: A touch of entry 1 sets bit 31, clears bits 28 and 27, and keeps bits 30, 29 and 26.
- R7: A touch of entry 2 sets bits 30 and 28, clears bit 26, and keeps bits 31, 29 and 27.
- R8: A touch of entry 3 sets bits 29, 27 and 26 and keeps bits 31, 30 and 28.
- R9: A touch never changes `csr_q[25:0]`.
- R10: When a write and a touch occur in the same cycle, the write wins and the touch is dropped.
- R11: With neither a write nor a touch, `csr_q` holds its value.
- R12: After a touch of entry k, `victim_idx` is not k unless `state_bad` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Software write strobe for the control word |
| csr_wr_data | input | 32 | Value to load into the control word |
| touch_valid | input | 1 | Hit or refill strobe |
| touch_idx | input | 2 | Entry that was hit or refilled |
| csr_q | output | 32 | Current control word |
| victim_idx | output | 2 | Entry to replace on the next refill |
| state_bad | output | 1 | Order field selects no entry |

## Verification
Several properties are checked on every cycle:
- a write lands on the next cycle and beats a simultaneous touch;
- a touch leaves the bits outside the field alone;
- idle cycles hold the word;
- at most one entry pattern ever matches;
- a just-touched entry is never the victim of a consistent state;
- a bad state drives victim 0.

The exact mask values for each entry, the victim decoded from each specific pattern, and the full touch cycle 3, 2, 1, 0 back to the reset state can only be shown by the bench's vector scenarios.

// File: rtl/tlb_lru_pkg.sv
package tlb_lru_pkg;

   // number of entry pairs tracked by the order field
   function automatic int pair_count(input int n);
      return (n * (n - 1)) / 2;
   endfunction

   // field bit holding the relative order of entries lo < hi;
   // pairs are listed lexicographically starting at the field MSB
   function automatic int pair_bit(input int lo, input int hi, input int n);
      int pos;
      pos = 0;
      for (int a = 0; a < lo; a++) pos += n - 1 - a;
      pos += hi - lo - 1;
      return pair_count(n) - 1 - pos;
   endfunction

endpackage

// File: rtl/lru_use_mask.sv
module lru_use_mask
   import tlb_lru_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int FIELD_W = (ENTRIES * (ENTRIES - 1)) / 2
) (
   input  logic [IDX_W-1:0]   touch_idx,
   output logic [FIELD_W-1:0] and_mask,
   output logic [FIELD_W-1:0] or_mask
);

   // a pair bit of 1 means the higher entry was used after the lower one
   for (genvar lo = 0; lo < ENTRIES; lo++) begin : g_lo
      for (genvar hi = lo + 1; hi < ENTRIES; hi++) begin : g_hi
         localparam int B = pair_bit(lo, hi, ENTRIES);
         assign and_mask[B] = (touch_idx != IDX_W'(lo));
         assign or_mask[B]  = (touch_idx == IDX_W'(hi));
      end
   end

endmodule

// File: rtl/lru_victim_decode.sv
module lru_victim_decode
   import tlb_lru_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int FIELD_W = (ENTRIES * (ENTRIES - 1)) / 2
) (
   input  logic [FIELD_W-1:0] order_field,
   output logic [ENTRIES-1:0] entry_match,
   output logic [IDX_W-1:0]   victim_idx,
   output logic               state_bad
);

   // entry k is oldest when every pair that includes it says the other was later
   for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
      logic oldest_k;
      always_comb begin
         oldest_k = 1'b1;
         for (int a = 0; a < ENTRIES; a++) begin
            if (a < k) begin
               if (order_field[pair_bit(a, k, ENTRIES)]) oldest_k = 1'b0;
            end else if (a > k) begin
               if (!order_field[pair_bit(k, a, ENTRIES)]) oldest_k = 1'b0;
            end
         end
      end
      assign entry_match[k] = oldest_k;
   end

   // lowest index wins
   always_comb begin
      victim_idx = '0;
      state_bad  = 1'b1;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (entry_match[k]) begin
            victim_idx = IDX_W'(k);
            state_bad  = 1'b0;
         end
      end
   end

endmodule

// File: rtl/lru_state_reg.sv
module lru_state_reg #(
   parameter int          REG_W       = 32,
   parameter int          FIELD_LSB   = 26,
   parameter int          FIELD_W     = 6,
   parameter logic [31:0] RESET_VALUE = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               upd_en,
   input  logic [FIELD_W-1:0] and_mask,
   input  logic [FIELD_W-1:0] or_mask,
   output logic [REG_W-1:0]   q
);

   localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= RESET_VALUE[REG_W-1:0];
      end else if (wr_en) begin
         q <= wr_data;
      end else if (upd_en) begin
         q[FIELD_MSB:FIELD_LSB] <= (q[FIELD_MSB:FIELD_LSB] & and_mask) | or_mask;
      end
   end

endmodule

// File: rtl/tlb_lru_tracker.sv
module tlb_lru_tracker #(
   parameter int          ENTRIES     = 4,
   parameter int          REG_W       = 32,
   parameter int          FIELD_LSB   = 26,
   parameter logic [31:0] RESET_VALUE = 32'h0,
   localparam int         IDX_W       = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_wr_en,
   input  logic [REG_W-1:0] csr_wr_data,
   input  logic             touch_valid,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [REG_W-1:0] csr_q,
   output logic [IDX_W-1:0] victim_idx,
   output logic             state_bad
);

   localparam int FIELD_W   = (ENTRIES * (ENTRIES - 1)) / 2;
   localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_lru_tracker: ENTRIES must be at least 2");
   end
   if (FIELD_MSB >= REG_W) begin : g_bad_field
      $error("tlb_lru_tracker: order field does not fit in the register");
   end
   if (REG_W > 32) begin : g_bad_width
      $error("tlb_lru_tracker: REG_W above 32 is not supported");
   end

   logic [FIELD_W-1:0] and_mask;
   logic [FIELD_W-1:0] or_mask;
   logic [ENTRIES-1:0] entry_match;

   lru_use_mask #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .FIELD_W(FIELD_W)) mask_i (
      .touch_idx (touch_idx),
      .and_mask  (and_mask),
      .or_mask   (or_mask)
   );

   lru_state_reg #(
      .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .RESET_VALUE(RESET_VALUE)
   ) state_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (csr_wr_en),
      .wr_data  (csr_wr_data),
      .upd_en   (touch_valid),
      .and_mask (and_mask),
      .or_mask  (or_mask),
      .q        (csr_q)
   );

   lru_victim_decode #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .FIELD_W(FIELD_W)) dec_i (
      .order_field (csr_q[FIELD_MSB:FIELD_LSB]),
      .entry_match (entry_match),
      .victim_idx  (victim_idx),
      .state_bad   (state_bad)
   );

endmodule

// File: rtl/tlb_lru_tracker_chk.sv
module tlb_lru_tracker_chk #(
   parameter int ENTRIES   = 4,
   parameter int REG_W     = 32,
   parameter int FIELD_LSB = 26,
   parameter int IDX_W     = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             csr_wr_en,
   input logic [REG_W-1:0] csr_wr_data,
   input logic             touch_valid,
   input logic [IDX_W-1:0] touch_idx,
   input logic [REG_W-1:0] csr_q,
   input logic [IDX_W-1:0] victim_idx,
   input logic             state_bad,
   input logic [ENTRIES-1:0] entry_match
);

   a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr_en |=> csr_q == $past(csr_wr_data));

   a_r10_write_beats_touch: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr_en && touch_valid) |=> csr_q == $past(csr_wr_data));

   a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_wr_en && !touch_valid) |=> $stable(csr_q));

   a_r12_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_valid && !csr_wr_en) |=> (state_bad || victim_idx != $past(touch_idx)));

   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(entry_match));

   a_r4_bad_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
      state_bad |-> victim_idx == '0);

   if (FIELD_LSB > 0) begin : g_low
      a_r9_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
         !csr_wr_en |=> csr_q[FIELD_LSB-1:0] == $past(csr_q[FIELD_LSB-1:0]));
   end

endmodule

bind tlb_lru_tracker tlb_lru_tracker_chk #(
   .ENTRIES(ENTRIES), .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .IDX_W(IDX_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
   .touch_valid(touch_valid), .touch_idx(touch_idx), .csr_q(csr_q),
   .victim_idx(victim_idx), .state_bad(state_bad), .entry_match(entry_match)
);

// File: tb/tlb_lru_tracker_tb_top.sv
module tlb_lru_tracker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_wr_en;
   logic [31:0] csr_wr_data;
   logic        touch_valid;
   logic [1:0]  touch_idx;
   logic [31:0] csr_q;
   logic [1:0]  victim_idx;
   logic        state_bad;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tlb_lru_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
      .touch_valid(touch_valid), .touch_idx(touch_idx), .csr_q(csr_q),
      .victim_idx(victim_idx), .state_bad(state_bad)
   );

   // rows: field before, touched entry, field after, {bad,victim} before and after
   localparam int NROWS = 8;
   localparam logic [5:0] PRE  [NROWS] = '{6'b000000, 6'b001011, 6'b011110, 6'b111000,
                                           6'b111111, 6'b111111, 6'b010001, 6'b000001};
   localparam logic [1:0] TCH  [NROWS] = '{2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd0, 2'd1, 2'd2};
   localparam logic [5:0] POST [NROWS] = '{6'b001011, 6'b011110, 6'b111000, 6'b000000,
                                           6'b111111, 6'b000111, 6'b110001, 6'b010100};
   localparam logic [2:0] VPRE [NROWS] = '{3'b011, 3'b010, 3'b001, 3'b000,
                                           3'b000, 3'b000, 3'b100, 3'b010};
   localparam logic [2:0] VPOST[NROWS] = '{3'b010, 3'b001, 3'b000, 3'b011,
                                           3'b000, 3'b001, 3'b100, 3'b011};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [31:0] v);
      @(negedge clk);
      csr_wr_en   = 1'b1;
      csr_wr_data = v;
      @(negedge clk);
      csr_wr_en   = 1'b0;
   endtask

   task automatic touch(input logic [1:0] k);
      @(negedge clk);
      touch_valid = 1'b1;
      touch_idx   = k;
      @(negedge clk);
      touch_valid = 1'b0;
   endtask

   function automatic string touch_tag(input logic [1:0] k);
      case (k)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; csr_wr_en = 1'b0; csr_wr_data = '0; touch_valid = 1'b0; touch_idx = '0;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 word in reset", csr_q, 32'h0);
      check("R1 victim in reset", {29'd0, state_bad, victim_idx}, 32'h3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 word after reset", csr_q, 32'h0);
      check("R1 victim after reset", {29'd0, state_bad, victim_idx}, 32'h3);

      // table walk: R2, R3, R4, R5-R8, R9, R12
      for (int i = 0; i < NROWS; i++) begin
         logic [25:0] low;
         low = 26'(32'h0123_4567 * (i + 1));
         write_word({PRE[i], low});
         check("R2 write lands", csr_q, {PRE[i], low});
         check(VPRE[i][2] ? "R4 decode bad" : "R3 decode",
               {29'd0, state_bad, victim_idx}, {29'd0, VPRE[i]});
         touch(TCH[i]);
         check(touch_tag(TCH[i]), {26'd0, csr_q[31:26]}, {26'd0, POST[i]});
         check("R9 low bits", {6'd0, csr_q[25:0]}, {6'd0, low});
         check("R12 victim after touch", {29'd0, state_bad, victim_idx}, {29'd0, VPOST[i]});
      end

      // R11 idle cycles hold the word
      write_word(32'h2C00_BEEF);
      repeat (4) @(negedge clk);
      check("R11 hold", csr_q, 32'h2C00_BEEF);

      // R10 write with a simultaneous touch of entry 0
      @(negedge clk);
      csr_wr_en = 1'b1; csr_wr_data = 32'hFC00_00AB;
      touch_valid = 1'b1; touch_idx = 2'd0;
      @(negedge clk);
      csr_wr_en = 1'b0; touch_valid = 1'b0;
      check("R10 write wins", csr_q, 32'hFC00_00AB);

      // R4 direct bad pattern and R3 entry 2 pattern
      write_word(32'h4400_0000);
      check("R4 bad flag", {31'd0, state_bad}, 32'h1);
      check("R4 victim zero", {30'd0, victim_idx}, 32'h0);
      write_word(32'h0400_0000);
      check("R3 entry 2", {29'd0, state_bad, victim_idx}, 32'h2);

      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset mid-run", csr_q, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule